// File: doc/BRIEF.md
# Burst-Capable Frame Buffer CPU Port

This block gives a 16-bit processor bus a window into a video memory whose word address is 20 bits wide. The address is kept as two separate 10-bit counters: a column counter and a line counter. The processor loads each counter with its own bus write. After that it moves words through a single data register. Each data access can also move the column counter forward and move the line counter forward or back, so a run of pixels along a line, or down a column, needs no further address writes.

The six bus select lines carry two things at once: which register is addressed and how the counters step after a data access. In the cycle of a data access the block takes the memory away from the display scan. It drives the memory with the processor address, the write strobe and the data for that one cycle. The bus is never held off. The display may show a few wrong pixels as a result. Read data comes back in the cycle after the access, flagged by a valid strobe.

The select lines are decoded as follows:

- Bits [1:0] choose the target: 00 = column load, 01 = line load, 10 = data, 11 = no target.
- Bit [2] is the column step: 1 = +1.
- Bits [4:3] are the line step: 01 = +1, 10 = -1, 00 or 11 = hold.
- Bit [5] must be 0 for the command to act.

A two-state controller tracks the read return:

- `PH_SCAN`: no read is returning.
- `PH_RET`: the previous cycle issued a read, so `cpu_rvalid` is high.

Its transitions are:

- scan-to-return on a data read.
- return-to-return on a back-to-back read.
- return-to-scan on any other cycle.

Top module: `fb_access_port`

## Requirements
- R1: After reset both counters are 0, `cpu_rvalid` is 0, and the controller is in `PH_SCAN`.
- R2: Target 00 loads the column counter from `cpu_wdata[9:0]`. It does not drive the memory.
- R3: Target 01 loads the line counter from `cpu_wdata[9:0]`. It does not drive the memory.
- R4: A data write (target 10, `cpu_we`=1) drives the memory in the same cycle:
  - `ram_addr` = {line, column};
  - `ram_we` = 1;
  - `ram_wdata` = `cpu_wdata`.
- R5: A data read (target 10, `cpu_we`=0) puts {line, column} on `ram_addr` with `ram_we`=0. In the next cycle `cpu_rvalid` is 1 and `cpu_rdata` carries the memory word for that address. In every other cycle `cpu_rvalid` is 0.
- R6: After a data access with bit 2 set, the column counter steps by +1. It wraps from 1023 to 0 and leaves the line counter unchanged.
- R7: After a data access, line step 01 adds 1 and line step 10 subtracts 1 to the line counter. Both wrap modulo 1024. Line step 00 or 11 leaves the line counter unchanged.
- R8: Step bits have no effect on a counter load. The loaded counter takes the load value, and the other counter keeps its value.
- R9: With `cpu_sel` low, `ram_addr` equals `scan_addr` and `ram_we` is 0, whatever `cpu_we` is.
- R10: A select with target 11, or with bit 5 set, drives no memory cycle and changes no counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel-rate clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_sel | input | 1 | Bus cycle addressed to this port |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | 6 | Register and step select lines |
| cpu_wdata | input | 16 | Bus write data |
| cpu_rdata | output | 16 | Read data, valid with `cpu_rvalid` |
| cpu_rvalid | output | 1 | Read data returned this cycle |
| scan_addr | input | 20 | Display scan address |
| ram_addr | output | 20 | Memory word address |
| ram_we | output | 1 | Memory write strobe |
| ram_wdata | output | 16 | Memory write data |
| ram_rdata | input | 16 | Memory read data, one cycle after the address |

## Verification
In a burst of reads, the return of one read and the issue of the next fall in the same cycle. In that cycle the counters also step. The bench runs back-to-back column-stepping reads, and in each cycle it checks two things against an address-derived memory pattern: that `cpu_rdata` belongs to the previous address, and that `ram_addr` already shows the stepped address. Counter wrap across both edges, line decrement from 0, and commands that must do nothing are judged by the address that the next data access puts on `ram_addr`.

// File: rtl/fbp_pkg.sv
package fbp_pkg;

    localparam int SEL_W = 6;

    typedef enum logic [1:0] {
        TGT_XLOAD = 2'b00,
        TGT_YLOAD = 2'b01,
        TGT_DATA  = 2'b10,
        TGT_NONE  = 2'b11
    } tgt_e;

    typedef enum logic [1:0] {
        YS_HOLD  = 2'b00,
        YS_UP    = 2'b01,
        YS_DOWN  = 2'b10,
        YS_HOLD2 = 2'b11
    } ystep_e;

    typedef enum logic {
        PH_SCAN = 1'b0,
        PH_RET  = 1'b1
    } phase_e;

    typedef struct packed {
        logic ld_x;
        logic ld_y;
        logic acc;
        logic rd;
        logic wr;
        logic x_up;
        logic y_up;
        logic y_dn;
    } cmd_t;

endpackage

// File: rtl/fbp_decode.sv
module fbp_decode
    import fbp_pkg::*;
(
    input  logic             sel,
    input  logic             we,
    input  logic [SEL_W-1:0] addr,
    output cmd_t             cmd
);
    tgt_e   tgt;
    ystep_e ys;

    always_comb begin
        tgt = tgt_e'(addr[1:0]);
        ys  = ystep_e'(addr[4:3]);
        cmd = '0;
        if (sel && !addr[5]) begin
            unique case (tgt)
                TGT_XLOAD: cmd.ld_x = 1'b1;
                TGT_YLOAD: cmd.ld_y = 1'b1;
                TGT_DATA: begin
                    cmd.acc  = 1'b1;
                    cmd.wr   = we;
                    cmd.rd   = !we;
                    cmd.x_up = addr[2];
                    unique case (ys)
                        YS_UP:   cmd.y_up = 1'b1;
                        YS_DOWN: cmd.y_dn = 1'b1;
                        YS_HOLD, YS_HOLD2: ;
                    endcase
                end
                TGT_NONE: ;
            endcase
        end
    end
endmodule

// File: rtl/fbp_axis_ctr.sv
module fbp_axis_ctr #(
    parameter int W     = 10,
    parameter bit BIDIR = 1'b1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] din,
    input  logic         up,
    input  logic         dn,
    output logic [W-1:0] q
);
    localparam logic [W-1:0] ONE = W'(1);

    logic dn_eff;

    generate
        if (BIDIR) begin : g_bidir
            assign dn_eff = dn;
        end else begin : g_uponly
            logic unused_dn;
            assign unused_dn = dn;
            assign dn_eff    = 1'b0;
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (!rst_n)      q <= '0;
        else if (load)   q <= din;
        else if (up)     q <= q + ONE;
        else if (dn_eff) q <= q - ONE;
    end

    assert_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> q == $past(din));
    assert_up_wrap_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && up) |=> q == W'($past(q) + ONE));
    assert_down_wrap_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && !up && dn_eff) |=> q == W'($past(q) - ONE));
    assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && !up && !dn_eff) |=> $stable(q));
endmodule

// File: rtl/fbp_ctrl.sv
module fbp_ctrl
    import fbp_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic rd_req,
    output logic rvalid
);
    phase_e state, state_nx;

    always_comb begin
        unique case (state)
            PH_SCAN: state_nx = rd_req ? PH_RET : PH_SCAN;
            PH_RET:  state_nx = rd_req ? PH_RET : PH_SCAN;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= PH_SCAN;
        else        state <= state_nx;
    end

    always_comb begin
        unique case (state)
            PH_SCAN: rvalid = 1'b0;
            PH_RET:  rvalid = 1'b1;
        endcase
    end

    assert_rvalid_follows_read_R5: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req |=> rvalid);
    assert_rvalid_only_after_read_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_req |=> !rvalid);
endmodule

// File: rtl/fb_access_port.sv
module fb_access_port
    import fbp_pkg::*;
#(
    parameter int AXIS_W = 10,
    parameter int DATA_W = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cpu_sel,
    input  logic                cpu_we,
    input  logic [SEL_W-1:0]    cpu_addr,
    input  logic [DATA_W-1:0]   cpu_wdata,
    output logic [DATA_W-1:0]   cpu_rdata,
    output logic                cpu_rvalid,
    input  logic [2*AXIS_W-1:0] scan_addr,
    output logic [2*AXIS_W-1:0] ram_addr,
    output logic                ram_we,
    output logic [DATA_W-1:0]   ram_wdata,
    input  logic [DATA_W-1:0]   ram_rdata
);
    localparam int ADDR_W = 2 * AXIS_W;

    cmd_t              cmd;
    logic [AXIS_W-1:0] col_q, line_q;

    fbp_decode u_decode (
        .sel  (cpu_sel),
        .we   (cpu_we),
        .addr (cpu_addr),
        .cmd  (cmd)
    );

    fbp_axis_ctr #(.W(AXIS_W), .BIDIR(1'b0)) u_col (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (cmd.ld_x),
        .din   (cpu_wdata[AXIS_W-1:0]),
        .up    (cmd.x_up),
        .dn    (1'b0),
        .q     (col_q)
    );

    fbp_axis_ctr #(.W(AXIS_W), .BIDIR(1'b1)) u_line (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (cmd.ld_y),
        .din   (cpu_wdata[AXIS_W-1:0]),
        .up    (cmd.y_up),
        .dn    (cmd.y_dn),
        .q     (line_q)
    );

    fbp_ctrl u_ctrl (
        .clk    (clk),
        .rst_n  (rst_n),
        .rd_req (cmd.rd),
        .rvalid (cpu_rvalid)
    );

    always_comb begin
        ram_addr  = cmd.acc ? ADDR_W'({line_q, col_q}) : scan_addr;
        ram_we    = cmd.wr;
        ram_wdata = cpu_wdata;
        cpu_rdata = ram_rdata;
    end

    assert_scan_owns_ram_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !cpu_sel |-> (ram_addr == scan_addr && !ram_we));
    assert_no_target_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_sel && (cpu_addr[1:0] == 2'b11 || cpu_addr[5])) |-> (!ram_we && ram_addr == scan_addr));
    assert_no_target_keeps_col_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_sel && cpu_addr[5]) |=> $stable(col_q));
endmodule

// File: tb/test_fb_access_port.sv
`timescale 1ns/1ps
module test_fb_access_port;
    localparam int AW = 10;
    localparam int DW = 16;
    localparam int NV = 16;

    typedef struct packed {
        logic [3:0]  rtag;
        logic        we;
        logic [5:0]  a;
        logic [15:0] wd;
        logic [19:0] ea;
        logic        ew;
    } vec_t;

    localparam logic [19:0] SCAN0 = 20'hABCDE;

    // Column 5, line 3 -> 0x00C05; wraps and decrements per R6/R7.
    localparam vec_t VECS [NV] = '{
        '{4'd2,  1'b1, 6'b000000, 16'h0005, SCAN0,    1'b0}, // R2 load column 5
        '{4'd3,  1'b1, 6'b000001, 16'h0003, SCAN0,    1'b0}, // R3 load line 3
        '{4'd4,  1'b1, 6'b000010, 16'h1111, 20'h00C05, 1'b1}, // R4 write, no step
        '{4'd6,  1'b1, 6'b000110, 16'h2222, 20'h00C05, 1'b1}, // R6 write, column +1
        '{4'd5,  1'b0, 6'b000010, 16'h0000, 20'h00C06, 1'b0}, // R5 read shows address
        '{4'd8,  1'b1, 6'b001100, 16'hFFFF, SCAN0,    1'b0}, // R8 load column 1023, steps ignored
        '{4'd6,  1'b1, 6'b001110, 16'h3333, 20'h00FFF, 1'b1}, // R6 R7 write, column +1, line +1
        '{4'd6,  1'b1, 6'b000010, 16'h4444, 20'h01000, 1'b1}, // R6 column wrapped, no carry
        '{4'd3,  1'b1, 6'b000001, 16'hFC00, SCAN0,    1'b0}, // R3 load line 0
        '{4'd7,  1'b1, 6'b010010, 16'h5555, 20'h00000, 1'b1}, // R7 write, line -1
        '{4'd7,  1'b1, 6'b000010, 16'h6666, 20'hFFC00, 1'b1}, // R7 line wrapped to 1023
        '{4'd10, 1'b1, 6'b011111, 16'h1234, SCAN0,    1'b0}, // R10 target 11
        '{4'd10, 1'b1, 6'b100110, 16'h4321, SCAN0,    1'b0}, // R10 bit5 set
        '{4'd7,  1'b1, 6'b011010, 16'h7777, 20'hFFC00, 1'b1}, // R7 line step 11 holds
        '{4'd7,  1'b1, 6'b001010, 16'h8888, 20'hFFC00, 1'b1}, // R7 line +1 (wrap up)
        '{4'd7,  1'b1, 6'b000010, 16'h9999, 20'h00000, 1'b1}  // R7 line wrapped to 0
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cpu_sel = 1'b0;
    logic          cpu_we = 1'b0;
    logic [5:0]    cpu_addr = '0;
    logic [DW-1:0] cpu_wdata = '0;
    logic [DW-1:0] cpu_rdata;
    logic          cpu_rvalid;
    logic [19:0]   scan_addr = SCAN0;
    logic [19:0]   ram_addr;
    logic          ram_we;
    logic [DW-1:0] ram_wdata;
    logic [DW-1:0] ram_rdata = '0;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    fb_access_port #(.AXIS_W(AW), .DATA_W(DW)) i_fb_access_port (
        .clk(clk), .rst_n(rst_n), .cpu_sel(cpu_sel), .cpu_we(cpu_we),
        .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
        .cpu_rvalid(cpu_rvalid), .scan_addr(scan_addr), .ram_addr(ram_addr),
        .ram_we(ram_we), .ram_wdata(ram_wdata), .ram_rdata(ram_rdata)
    );

    function automatic logic [15:0] pat(input logic [19:0] a);
        return a[15:0] ^ {a[19:16], 12'h5A5};
    endfunction

    // synchronous memory model: read word derived from address
    always @(posedge clk) ram_rdata <= pat(ram_addr);

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic drive(input logic s, input logic w, input logic [5:0] a, input logic [15:0] d);
        @(negedge clk);
        cpu_sel = s; cpu_we = w; cpu_addr = a; cpu_wdata = d;
        #1;
    endtask

    task automatic finish_run;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired actual=%h expected=%h", 0, 1);
            finish_run();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1 reset state at the ports
        check(cpu_rvalid == 1'b0, "R1 rvalid", 32'(cpu_rvalid), 0);
        check(ram_addr == SCAN0, "R1 scan addr", 32'(ram_addr), 32'(SCAN0));

        for (int i = 0; i < NV; i++) begin
            drive(1'b1, VECS[i].we, VECS[i].a, VECS[i].wd);
            check(ram_addr == VECS[i].ea, $sformatf("R%0d vec %0d addr", VECS[i].rtag, i),
                  32'(ram_addr), 32'(VECS[i].ea));
            check(ram_we == VECS[i].ew, $sformatf("R%0d vec %0d we", VECS[i].rtag, i),
                  32'(ram_we), 32'(VECS[i].ew));
            if (VECS[i].ew)
                check(ram_wdata == VECS[i].wd, $sformatf("R%0d vec %0d wdata", VECS[i].rtag, i),
                      32'(ram_wdata), 32'(VECS[i].wd));
        end

        // R9: no select, write strobe high, scan moves
        drive(1'b0, 1'b1, 6'b000010, 16'hDEAD);
        scan_addr = 20'h12345;
        #0.5;
        check(ram_addr == 20'h12345 && !ram_we, "R9 scan passthrough", 32'(ram_addr), 32'h12345);

        // R1: reset mid-run clears counters
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        check(cpu_rvalid == 1'b0, "R1 rvalid after reset", 32'(cpu_rvalid), 0);
        drive(1'b1, 1'b0, 6'b000010, 16'h0);
        check(ram_addr == 20'h0, "R1 counters zero", 32'(ram_addr), 0);
        drive(1'b0, 1'b0, 6'b0, 16'h0);
        check(cpu_rvalid && cpu_rdata == pat(20'h0), "R5 read return at 0", 32'(cpu_rdata), 32'(pat(20'h0)));

        // R5 with R6: back-to-back column-stepping reads overlap return and issue
        drive(1'b1, 1'b1, 6'b000000, 16'd10);
        drive(1'b1, 1'b1, 6'b000001, 16'd2);
        drive(1'b1, 1'b0, 6'b000110, 16'h0);
        check(ram_addr == 20'h0080A && !cpu_rvalid, "R5 first read issue", 32'(ram_addr), 32'h0080A);
        drive(1'b1, 1'b0, 6'b000110, 16'h0);
        check(ram_addr == 20'h0080B, "R6 stepped address in burst", 32'(ram_addr), 32'h0080B);
        check(cpu_rvalid && cpu_rdata == pat(20'h0080A), "R5 first return", 32'(cpu_rdata), 32'(pat(20'h0080A)));
        drive(1'b0, 1'b0, 6'b000000, 16'h0);
        check(cpu_rvalid && cpu_rdata == pat(20'h0080B), "R5 second return", 32'(cpu_rdata), 32'(pat(20'h0080B)));
        drive(1'b0, 1'b0, 6'b000000, 16'h0);
        check(!cpu_rvalid, "R5 rvalid drops", 32'(cpu_rvalid), 0);

        done = 1'b1;
        finish_run();
    end
endmodule